// File: doc/BRIEF.md
# NOR Flash Operation Sequencer

This block sits between a client that wants whole flash operations (read a span, program a span, erase a range of sectors) and a frame engine that shifts one serial-flash transaction at a time. The client presents one request: an operation code, a start address, a byte length and an exclusive range end for erases. The sequencer then emits the frame commands that carry the operation out. Each command carries an opcode, an address and its width, a dummy count, a byte count, a byte offset into the client's data, a direction and a lane mode.

Programs are cut into chunks that never cross a page. Each chunk is wrapped in a write-enable frame before it and a status poll after it. The poll repeats until the flash reports idle. Erases walk the range in sector steps with the same write-enable and poll wrapping. Reads are a single frame. Capacity limits are checked in hardware. A frame that the engine aborts ends the whole operation with a transfer error.

Top module: `flash_op_sequencer`

## Requirements
- R1: A read (req_op 0) with nonzero length issues exactly one frame. That frame carries the configured read opcode, dummy count and lane mode, the request address and length, and cmd_rx = 1. No write-enable or poll frame goes with it.
- R2: A program (req_op 1) is split into chunks. Each chunk is the smaller of (PAGE_BYTES − address mod PAGE_BYTES) and the remaining bytes. Address and cmd_offset advance by the chunk length after each chunk. The program frame uses the configured program opcode and lane mode, zero dummy, and cmd_rx = 0.
- R3: Every program and every erase frame is preceded by a write-enable frame. That frame has opcode 0x06, lane mode 0 (single), address width 0, length 0 and cmd_rx = 0.
- R4: After each program or erase frame, a status frame is issued: opcode 0x05, single lane, length 1, cmd_rx = 1, no address. It repeats while bit 0 of cmd_status is 1, and the other status bits are ignored.
- R5: An erase (req_op 2) issues opcode 0x20 frames (single lane, length 0) at req_addr, req_addr+4096, … while the address is below req_end. A range with req_addr ≥ req_end completes with no frames.
- R6: With nonzero cfg_capacity, a read or program whose address+length exceeds capacity, or overflows the address width, ends with err and err_code 1 and no frames. A capacity of 0 disables every bound check.
- R7: With nonzero cfg_capacity, each erase step whose address is at or above capacity ends the operation with err_code 1 before that step's frames. Steps already done stand.
- R8: cmd_abort on an outstanding frame ends the operation with err and err_code 2, and no further frame is issued.
- R9: A read or program of length 0 that passes the bound check ends with done and no frames.
- R10: busy rises the cycle after a request is accepted and stays high through the single-cycle done or err pulse. done and err are never high together. req_valid is ignored while busy.
- R11: Operation code 3 ends with err and err_code 3 and no frames.
- R12: cmd_start is a one-cycle pulse. No new frame starts until the previous one has been answered with cmd_done.
- R13: cmd_addr_bits is 32 when cfg_addr32 is 1 and 24 otherwise, for every frame that carries an address. Lane modes are encoded as 0 single, 1 dual data, 2 dual address+data, 3 quad data, 4 quad address+data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr | input | AW | Start address |
| req_len | input | LW | Byte length for read and program |
| req_end | input | AW | Exclusive end address for erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 1 out of range, 2 transfer, 3 bad operation; valid with err |
| cfg_capacity | input | AW | Flash size in bytes, 0 disables checks |
| cfg_addr32 | input | 1 | Four-byte addressing |
| cfg_rd_opcode | input | 8 | Read opcode |
| cfg_rd_dummy | input | 8 | Read dummy cycles |
| cfg_rd_lanes | input | 3 | Read lane mode |
| cfg_pg_opcode | input | 8 | Program opcode |
| cfg_pg_lanes | input | 3 | Program lane mode |
| cmd_start | output | 1 | Frame start pulse |
| cmd_opcode | output | 8 | Frame opcode |
| cmd_addr | output | AW | Frame address |
| cmd_addr_bits | output | 6 | Address width in bits, 0 when no address |
| cmd_dummy | output | 8 | Dummy cycles |
| cmd_len | output | LW | Data bytes |
| cmd_offset | output | LW | Byte offset into the client's data |
| cmd_rx | output | 1 | 1 receive, 0 transmit |
| cmd_lanes | output | 3 | Lane mode |
| cmd_done | input | 1 | Frame completed |
| cmd_abort | input | 1 | Frame aborted |
| cmd_status | input | 8 | Status byte returned by a poll frame |

## Verification
A program that starts a few bytes before a page edge and ends past the next one gives a short head chunk, full middle chunks and a short tail. A wrong room calculation would emit a chunk that spills into the next page or a zero-length frame. Poll rounds return busy several times with the other status bits set, so a sequencer that moved on early, or that looked at the whole byte, would skip or add frames. Bound checks are driven at exact capacity, one byte past it, and with an address that wraps the address width. An erase range that crosses capacity partway shows whether the check is done per step. Aborts on a mid-sequence frame and on a read, and a second request pulsed during a busy operation, show whether the sequencer stops cleanly and ignores intruders.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    EC_NONE  = 2'd0,
    EC_RANGE = 2'd1,
    EC_XFER  = 2'd2,
    EC_OP    = 2'd3
  } ferr_e;

  typedef enum logic [1:0] {
    STEP_WREN = 2'd0,
    STEP_MAIN = 2'd1,
    STEP_POLL = 2'd2
  } fstep_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2,
    FS_FIN   = 2'd3
  } fstate_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_STAT  = 8'h05;
  localparam logic [7:0] OPC_SECT  = 8'h20;
  localparam logic [2:0] LANE_ONE  = 3'd0;

endpackage

// File: rtl/flash_range_check.sv
`timescale 1ns/1ps
module flash_range_check #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] cap,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic          span_bad,
  output logic          point_bad
);
  localparam int SW = AW + 1;

  function automatic logic [SW-1:0] span_end(input logic [AW-1:0] b, input logic [LW-1:0] n);
    return {1'b0, b} + {{(SW-LW){1'b0}}, n};
  endfunction

  logic limit_on;
  assign limit_on  = (cap != '0);
  assign span_bad  = limit_on && (span_end(base, len) > {1'b0, cap});
  assign point_bad = limit_on && (base >= cap);
endmodule

// File: rtl/flash_page_chunk.sv
`timescale 1ns/1ps
module flash_page_chunk #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] remain,
  output logic [LW-1:0] chunk
);
  localparam int PG_LG = $clog2(PAGE_BYTES);

  function automatic logic [LW-1:0] page_room(input logic [AW-1:0] a);
    return LW'(PAGE_BYTES) - {{(LW-PG_LG){1'b0}}, a[PG_LG-1:0]};
  endfunction

  logic [LW-1:0] room;
  assign room  = page_room(addr);
  assign chunk = (remain < room) ? remain : room;
endmodule

// File: rtl/flash_cmd_build.sv
`timescale 1ns/1ps
module flash_cmd_build
  import flash_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  fstep_e        step,
  input  fop_e          op,
  input  logic [AW-1:0] cur_addr,
  input  logic [LW-1:0] chunk,
  input  logic [LW-1:0] rd_len,
  input  logic [LW-1:0] offset,
  input  logic          cfg_addr32,
  input  logic [7:0]    cfg_rd_opcode,
  input  logic [7:0]    cfg_rd_dummy,
  input  logic [2:0]    cfg_rd_lanes,
  input  logic [7:0]    cfg_pg_opcode,
  input  logic [2:0]    cfg_pg_lanes,
  output logic [7:0]    opcode,
  output logic [AW-1:0] addr,
  output logic [5:0]    addr_bits,
  output logic [7:0]    dummy,
  output logic [LW-1:0] len,
  output logic [LW-1:0] data_ofs,
  output logic          rx,
  output logic [2:0]    lanes
);
  logic [5:0] abits;
  assign abits = cfg_addr32 ? 6'd32 : 6'd24;

  always_comb begin
    opcode    = OPC_WREN;
    addr      = '0;
    addr_bits = '0;
    dummy     = '0;
    len       = '0;
    data_ofs  = '0;
    rx        = 1'b0;
    lanes     = LANE_ONE;
    unique case (step)
      STEP_POLL: begin
        opcode = OPC_STAT;
        len    = LW'(1);
        rx     = 1'b1;
      end
      STEP_MAIN: begin
        addr      = cur_addr;
        addr_bits = abits;
        unique case (op)
          OP_READ: begin
            opcode = cfg_rd_opcode;
            dummy  = cfg_rd_dummy;
            len    = rd_len;
            rx     = 1'b1;
            lanes  = cfg_rd_lanes;
          end
          OP_PROG: begin
            opcode   = cfg_pg_opcode;
            len      = chunk;
            data_ofs = offset;
            lanes    = cfg_pg_lanes;
          end
          default: opcode = OPC_SECT;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_op_sequencer.sv
`timescale 1ns/1ps
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int          AW           = 32,
  parameter int          LW           = 16,
  parameter int          PAGE_BYTES   = 256,
  parameter int          SECTOR_BYTES = 4096,
  parameter logic [7:0]  WIP_MASK     = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [AW-1:0] req_end,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  input  logic [AW-1:0] cfg_capacity,
  input  logic          cfg_addr32,
  input  logic [7:0]    cfg_rd_opcode,
  input  logic [7:0]    cfg_rd_dummy,
  input  logic [2:0]    cfg_rd_lanes,
  input  logic [7:0]    cfg_pg_opcode,
  input  logic [2:0]    cfg_pg_lanes,
  output logic          cmd_start,
  output logic [7:0]    cmd_opcode,
  output logic [AW-1:0] cmd_addr,
  output logic [5:0]    cmd_addr_bits,
  output logic [7:0]    cmd_dummy,
  output logic [LW-1:0] cmd_len,
  output logic [LW-1:0] cmd_offset,
  output logic          cmd_rx,
  output logic [2:0]    cmd_lanes,
  input  logic          cmd_done,
  input  logic          cmd_abort,
  input  logic [7:0]    cmd_status
);
  localparam int SW = AW + 1;

  fstate_e       state, nxt_state;
  fstep_e        step, nxt_step;
  ferr_e         code_q, nxt_code;
  fop_e          op_q;
  logic [AW-1:0] cur_addr, end_q;
  logic [LW-1:0] remain, len_q, offset;
  logic          load, adv_chunk, adv_sector;

  // named events for the checker
  logic ev_accept, ev_frame_ok, ev_frame_abort, flash_wip;
  assign ev_accept      = (state == FS_IDLE) && req_valid;
  assign ev_frame_ok    = (state == FS_WAIT) && cmd_done && !cmd_abort;
  assign ev_frame_abort = (state == FS_WAIT) && cmd_abort;
  assign flash_wip      = |(cmd_status & WIP_MASK);

  // request bound check and next-sector bound check
  logic          req_span_bad, req_point_bad;
  logic          sec_span_unused, sec_point_bad;
  logic [SW-1:0] nxt_sector;
  logic          sector_last;

  assign nxt_sector  = {1'b0, cur_addr} + SW'(SECTOR_BYTES);
  assign sector_last = nxt_sector >= {1'b0, end_q};

  flash_range_check #(.AW(AW), .LW(LW)) u_req_chk (
    .cap(cfg_capacity), .base(req_addr), .len(req_len),
    .span_bad(req_span_bad), .point_bad(req_point_bad)
  );

  flash_range_check #(.AW(AW), .LW(LW)) u_sec_chk (
    .cap(cfg_capacity), .base(nxt_sector[AW-1:0]), .len('0),
    .span_bad(sec_span_unused), .point_bad(sec_point_bad)
  );

  logic [LW-1:0] chunk;
  flash_page_chunk #(.AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr(cur_addr), .remain(remain), .chunk(chunk)
  );

  flash_cmd_build #(.AW(AW), .LW(LW)) u_build (
    .step(step), .op(op_q), .cur_addr(cur_addr), .chunk(chunk),
    .rd_len(len_q), .offset(offset), .cfg_addr32(cfg_addr32),
    .cfg_rd_opcode(cfg_rd_opcode), .cfg_rd_dummy(cfg_rd_dummy),
    .cfg_rd_lanes(cfg_rd_lanes), .cfg_pg_opcode(cfg_pg_opcode),
    .cfg_pg_lanes(cfg_pg_lanes), .opcode(cmd_opcode), .addr(cmd_addr),
    .addr_bits(cmd_addr_bits), .dummy(cmd_dummy), .len(cmd_len),
    .data_ofs(cmd_offset), .rx(cmd_rx), .lanes(cmd_lanes)
  );

  always_comb begin
    nxt_state  = state;
    nxt_step   = step;
    nxt_code   = code_q;
    load       = 1'b0;
    adv_chunk  = 1'b0;
    adv_sector = 1'b0;
    unique case (state)
      FS_IDLE: if (req_valid) begin
        load      = 1'b1;
        nxt_code  = EC_NONE;
        nxt_state = FS_FIN;
        unique case (fop_e'(req_op))
          OP_RSVD:  nxt_code = EC_OP;
          OP_ERASE: begin
            if (req_addr >= req_end) nxt_code = EC_NONE;
            else if (req_point_bad) nxt_code = EC_RANGE;
            else begin
              nxt_state = FS_ISSUE;
              nxt_step  = STEP_WREN;
            end
          end
          default: begin
            if (req_span_bad) nxt_code = EC_RANGE;
            else if (req_len != '0) begin
              nxt_state = FS_ISSUE;
              nxt_step  = (fop_e'(req_op) == OP_READ) ? STEP_MAIN : STEP_WREN;
            end
          end
        endcase
      end
      FS_ISSUE: nxt_state = FS_WAIT;
      FS_WAIT: begin
        if (ev_frame_abort) begin
          nxt_state = FS_FIN;
          nxt_code  = EC_XFER;
        end else if (ev_frame_ok) begin
          nxt_state = FS_ISSUE;
          unique case (step)
            STEP_WREN: nxt_step = STEP_MAIN;
            STEP_MAIN: begin
              if (op_q == OP_READ) nxt_state = FS_FIN;
              else nxt_step = STEP_POLL;
            end
            default: begin
              if (flash_wip) nxt_step = STEP_POLL;
              else if (op_q == OP_PROG) begin
                adv_chunk = 1'b1;
                nxt_step  = STEP_WREN;
                if (remain == chunk) nxt_state = FS_FIN;
              end else begin
                nxt_step = STEP_WREN;
                if (sector_last) nxt_state = FS_FIN;
                else if (sec_point_bad) begin
                  nxt_state = FS_FIN;
                  nxt_code  = EC_RANGE;
                end else adv_sector = 1'b1;
              end
            end
          endcase
        end
      end
      default: nxt_state = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      step     <= STEP_WREN;
      code_q   <= EC_NONE;
      op_q     <= OP_READ;
      cur_addr <= '0;
      end_q    <= '0;
      remain   <= '0;
      len_q    <= '0;
      offset   <= '0;
    end else begin
      state  <= nxt_state;
      step   <= nxt_step;
      code_q <= nxt_code;
      if (load) begin
        op_q     <= fop_e'(req_op);
        cur_addr <= req_addr;
        end_q    <= req_end;
        remain   <= req_len;
        len_q    <= req_len;
        offset   <= '0;
      end else if (adv_chunk) begin
        cur_addr <= cur_addr + AW'(chunk);
        remain   <= remain - chunk;
        offset   <= offset + chunk;
      end else if (adv_sector) begin
        cur_addr <= nxt_sector[AW-1:0];
      end
    end
  end

  assign busy      = (state != FS_IDLE);
  assign cmd_start = (state == FS_ISSUE);
  assign done      = (state == FS_FIN) && (code_q == EC_NONE);
  assign err       = (state == FS_FIN) && (code_q != EC_NONE);
  assign err_code  = (state == FS_FIN) ? code_q : EC_NONE;

endmodule

// File: rtl/flash_op_sequencer_chk.sv
`timescale 1ns/1ps
module flash_op_sequencer_chk #(
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ev_accept,
  input logic                          busy,
  input logic                          done,
  input logic                          err,
  input logic [1:0]                    err_code,
  input logic                          cmd_start,
  input logic [7:0]                    cmd_opcode,
  input logic [$clog2(PAGE_BYTES)-1:0] pg_ofs,
  input logic [5:0]                    cmd_addr_bits,
  input logic [LW-1:0]                 cmd_len,
  input logic                          cmd_rx,
  input logic                          cmd_done,
  input logic                          cmd_abort,
  input logic [7:0]                    cmd_status
);
  localparam int PG_LG = $clog2(PAGE_BYTES);

  logic       inflight;
  logic [7:0] last_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      last_op  <= 8'h00;
    end else begin
      if (cmd_start) begin
        inflight <= 1'b1;
        last_op  <= cmd_opcode;
      end else if (cmd_done || cmd_abort) inflight <= 1'b0;
    end
  end

  logic write_frame, prog_frame;
  logic [LW:0] page_span;
  assign write_frame = cmd_start && !cmd_rx && (cmd_addr_bits != 6'd0);
  assign prog_frame  = write_frame && (cmd_len != '0);
  assign page_span   = {{(LW+1-PG_LG){1'b0}}, pg_ofs} + {1'b0, cmd_len};

  assert_pulse_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !cmd_start);
  assert_wren_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    write_frame |-> (last_op == 8'h06));
  assert_page_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_frame |-> (page_span <= (LW+1)'(PAGE_BYTES)));
  assert_poll_again_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && last_op == 8'h05 && cmd_done && !cmd_abort && cmd_status[0])
      |=> (cmd_start && cmd_opcode == 8'h05));
  assert_abort_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && cmd_abort) |=> (err && err_code == 2'd2));
  assert_excl_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_start && !done && !err));
  assert_result_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !busy);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

endmodule

bind flash_op_sequencer flash_op_sequencer_chk #(
  .LW(LW), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .busy(busy),
  .done(done), .err(err), .err_code(err_code), .cmd_start(cmd_start),
  .cmd_opcode(cmd_opcode), .pg_ofs(cmd_addr[$clog2(PAGE_BYTES)-1:0]),
  .cmd_addr_bits(cmd_addr_bits), .cmd_len(cmd_len), .cmd_rx(cmd_rx),
  .cmd_done(cmd_done), .cmd_abort(cmd_abort), .cmd_status(cmd_status)
);

// File: tb/tb_flash_op_sequencer.sv
`timescale 1ns/1ps
module tb_flash_op_sequencer;
  localparam int AW = 32;
  localparam int LW = 16;

  typedef logic [89:0] cmdv_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic req_valid;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, req_end;
  logic [LW-1:0] req_len;
  logic busy, done, err;
  logic [1:0] err_code;
  logic [AW-1:0] cfg_capacity;
  logic cfg_addr32;
  logic [7:0] cfg_rd_opcode, cfg_rd_dummy, cfg_pg_opcode;
  logic [2:0] cfg_rd_lanes, cfg_pg_lanes;
  logic cmd_start;
  logic [7:0] cmd_opcode, cmd_dummy;
  logic [AW-1:0] cmd_addr;
  logic [5:0] cmd_addr_bits;
  logic [LW-1:0] cmd_len, cmd_offset;
  logic cmd_rx;
  logic [2:0] cmd_lanes;
  logic cmd_done, cmd_abort;
  logic [7:0] cmd_status;

  flash_op_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_end(req_end),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .cfg_capacity(cfg_capacity), .cfg_addr32(cfg_addr32),
    .cfg_rd_opcode(cfg_rd_opcode), .cfg_rd_dummy(cfg_rd_dummy),
    .cfg_rd_lanes(cfg_rd_lanes), .cfg_pg_opcode(cfg_pg_opcode),
    .cfg_pg_lanes(cfg_pg_lanes), .cmd_start(cmd_start),
    .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_addr_bits(cmd_addr_bits), .cmd_dummy(cmd_dummy),
    .cmd_len(cmd_len), .cmd_offset(cmd_offset), .cmd_rx(cmd_rx),
    .cmd_lanes(cmd_lanes), .cmd_done(cmd_done), .cmd_abort(cmd_abort),
    .cmd_status(cmd_status)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic cmdv_t mk(input int opc, input longint a, input int bits, input int dmy,
                               input int len, input int ofs, input int rx, input int ln);
    return {8'(opc), 32'(a), 6'(bits), 8'(dmy), 16'(len), 16'(ofs), 1'(rx), 3'(ln)};
  endfunction

  // Reference model: builds the expected frame list and result, then plays the frame engine.
  task automatic run(input string req, input int op, input longint addr, input int len,
                     input longint eaddr, input int pollb, input int abort_at, input bit poke);
    cmdv_t q[$];
    int code = 0;
    int bits = cfg_addr32 ? 32 : 24;
    longint cap = longint'(cfg_capacity);
    int lat = 0, idx = 0, bleft = pollb, wait_cnt = 0;
    bit finished = 0, cur_poll = 0, prev_start = 0;
    cmdv_t actv;
    if (op == 3) code = 3;
    else if (op == 2) begin
      longint a = addr;
      while (a < eaddr) begin
        if (cap != 0 && a >= cap) begin code = 1; break; end
        q.push_back(mk(6, 0, 0, 0, 0, 0, 0, 0));
        q.push_back(mk(32, a, bits, 0, 0, 0, 0, 0));
        for (int k = 0; k <= pollb; k++) q.push_back(mk(5, 0, 0, 0, 1, 0, 1, 0));
        a += 4096;
      end
    end else if (cap != 0 && addr + len > cap) code = 1;
    else if (len == 0) code = 0;
    else if (op == 0) q.push_back(mk(cfg_rd_opcode, addr, bits, cfg_rd_dummy, len, 0, 1, cfg_rd_lanes));
    else begin
      longint a = addr;
      int rem = len, ofs = 0;
      while (rem > 0) begin
        int n = 256 - int'(a % 256);
        if (n > rem) n = rem;
        q.push_back(mk(6, 0, 0, 0, 0, 0, 0, 0));
        q.push_back(mk(cfg_pg_opcode, a, bits, 0, n, ofs, 0, cfg_pg_lanes));
        for (int k = 0; k <= pollb; k++) q.push_back(mk(5, 0, 0, 0, 1, 0, 1, 0));
        a += n; ofs += n; rem -= n;
      end
    end
    if (abort_at >= 0 && abort_at < q.size()) begin
      while (q.size() > abort_at + 1) void'(q.pop_back());
      code = 2;
    end

    @(negedge clk);
    req_op = 2'(op); req_addr = AW'(addr); req_len = LW'(len); req_end = AW'(eaddr);
    req_valid = 1'b1;
    @(negedge clk);
    while (!finished && wait_cnt < 20000) begin
      wait_cnt++;
      req_valid = 1'b0;
      cmd_done = 1'b0; cmd_abort = 1'b0; cmd_status = 8'h00;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          if (idx - 1 == abort_at) cmd_abort = 1'b1;
          else begin
            cmd_done = 1'b1;
            if (cur_poll && bleft > 0) begin cmd_status = 8'h01; bleft--; end
            else cmd_status = cur_poll ? 8'hFE : 8'hFF;
          end
        end
      end
      if (cmd_start) begin
        actv = {cmd_opcode, cmd_addr, cmd_addr_bits, cmd_dummy, cmd_len, cmd_offset, cmd_rx, cmd_lanes};
        chk(lat == 0 && !prev_start, {req, " R12"}, "start while frame open", 96'(lat), 96'(0));
        if (q.size() == 0) chk(1'b0, req, "unexpected frame", 96'(actv), 96'(0));
        else begin
          chk(actv == q[0], req, "frame fields", 96'(actv), 96'(q[0]));
          void'(q.pop_front());
        end
        cur_poll = (cmd_opcode == 8'h05);
        if (!cur_poll) bleft = pollb;
        idx++;
        lat = 2;
        if (poke && idx == 1) begin
          req_valid = 1'b1; req_op = 2'd2; req_addr = '0; req_end = 32'h0001_0000;
        end
      end
      prev_start = cmd_start;
      if (done || err) begin
        chk(done == (code == 0) && err == (code != 0), req, "result kind", 96'({done, err}), 96'(code == 0 ? 2 : 1));
        chk(err_code == 2'(code), req, "err_code", 96'(err_code), 96'(code));
        chk(q.size() == 0, req, "frames missing", 96'(q.size()), 96'(0));
        finished = 1;
      end else chk(busy, {req, " R10"}, "busy held", 96'(busy), 96'(1));
      @(negedge clk);
    end
    if (!finished) chk(1'b0, req, "timeout", 96'(0), 96'(1));
    cmd_done = 1'b0; cmd_abort = 1'b0;
    chk(!busy && !done && !err, {req, " R10"}, "idle after result", 96'({busy, done, err}), 96'(0));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0; req_end = '0;
    cfg_capacity = '0; cfg_addr32 = 1'b0; cfg_rd_opcode = 8'hEB; cfg_rd_dummy = 8'd6;
    cfg_rd_lanes = 3'd4; cfg_pg_opcode = 8'h38; cfg_pg_lanes = 3'd4;
    cmd_done = 1'b0; cmd_abort = 1'b0; cmd_status = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !cmd_start, "R10 reset", "outputs in reset",
        96'({busy, done, err, cmd_start}), 96'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_start, "R10 reset", "outputs after reset",
        96'({busy, done, err, cmd_start}), 96'(0));

    run("R1 quad read", 0, 32'h0000_1234, 16, 0, 0, -1, 0);
    run("R9 empty read", 0, 32'h0000_0100, 0, 0, 0, -1, 0);
    run("R9 empty program", 1, 32'h0000_0100, 0, 0, 0, -1, 0);
    run("R2 R3 R4 page-crossing program", 1, 32'h0000_01F0, 16'h0220, 0, 2, -1, 0);
    run("R2 aligned page program", 1, 32'h0000_0400, 256, 0, 0, -1, 0);
    run("R5 R3 R4 sector range erase", 2, 32'h0000_1000, 0, 32'h0000_3800, 1, -1, 0);
    run("R5 empty erase range", 2, 32'h0000_5000, 0, 32'h0000_5000, 0, -1, 0);
    run("R11 reserved op", 3, 0, 0, 0, 0, -1, 0);
    run("R10 ignore request while busy", 0, 32'h0000_0040, 8, 0, 0, -1, 1);
    run("R6 no cap allows wrap", 0, 32'hFFFF_FFF0, 32, 0, 0, -1, 0);

    cfg_capacity = 32'h0001_0000;
    run("R6 read at exact end", 0, 32'h0000_FFF0, 16, 0, 0, -1, 0);
    run("R6 read one past end", 0, 32'h0000_FFF0, 17, 0, 0, -1, 0);
    run("R6 read wraps address", 0, 32'hFFFF_FFF0, 32, 0, 0, -1, 0);
    run("R6 program past end", 1, 32'h0000_FF00, 16'h0101, 0, 0, -1, 0);
    run("R7 erase first step out", 2, 32'h0001_0000, 0, 32'h0001_2000, 0, -1, 0);
    run("R7 erase crosses capacity", 2, 32'h0000_E000, 0, 32'h0001_2000, 0, -1, 0);
    cfg_capacity = '0;

    run("R8 abort mid program", 1, 32'h0000_00F0, 32, 0, 1, 3, 0);
    run("R8 abort on read", 0, 32'h0000_0000, 4, 0, 0, 0, 0);
    run("R8 abort on write-enable", 2, 32'h0000_0000, 0, 32'h0000_1000, 0, 0, 0);

    cfg_addr32 = 1'b1; cfg_rd_opcode = 8'h0B; cfg_rd_dummy = 8'd8; cfg_rd_lanes = 3'd0;
    cfg_pg_opcode = 8'h02; cfg_pg_lanes = 3'd1;
    run("R13 four-byte single read", 0, 32'h0123_4567, 3, 0, 0, -1, 0);
    run("R13 four-byte program", 1, 32'h0100_00FE, 4, 0, 1, -1, 0);
    run("R13 four-byte erase", 2, 32'h0200_0000, 0, 32'h0200_0001, 0, -1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule